// File: doc/BRIEF.md
# BCD Calendar Counter with Two-Stage Prescaler

This block keeps the time of day and the calendar date as packed BCD words and advances them by one second on each tick of a built-in prescaler. The prescaler is a cascade of a 7-bit first divider and a 15-bit second divider, both clocked by the kernel clock. Together they give one tick every (A+1)*(S+1) kernel cycles, where A and S are the two divider settings.

Time is held as seconds, minutes and hours, with a 24-hour or 12-hour format selected by an input. The date word holds day of month, month, weekday and a two-digit year meaning 2000 to 2099. Rollover follows real month lengths, and February gets 29 days in years divisible by four.

Software, or a controller block, raises `freeze` to stop the prescaler and the calendar. While frozen it may overwrite either word with a load strobe. Dropping `freeze` restarts counting from a cleared prescaler.

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset `time_q` and `date_q` are all zero and `sec_tick` is low. An all-zero word is a legal load value and counts on normally (00:00:00 becomes 00:00:01 after one tick).
- R2: While `freeze` is low, `sec_tick` pulses for one cycle every (A+1)*(S+1) cycles, with A = `div_async` and S = `div_sync`.
- R3: While `freeze` is high, no tick occurs and both words hold. After `freeze` falls, the first tick is seen (A+1)*(S+1)-1 cycles later, so the first calendar step lands exactly (A+1)*(S+1) cycles after release.
- R4: `load_time` and `load_date` write `time_wdata` and `date_wdata` only while `freeze` is high; while it is low they have no effect.
- R5: The time word holds seconds in bits 6:0, minutes in 14:8 and hours in 21:16, all in BCD, with the PM flag in bit 22. Seconds roll from 59 to 00 and carry into minutes; minutes roll from 59 to 00 and carry into hours.
- R6: With `hour12` low, hours run 00 to 23. The step 23:59:59 to 00:00:00 advances the date by one day.
- R7: With `hour12` high, hours run 12, 01 to 11. The step from 11 to 12 toggles bit 22. The step from 12 goes to 01. The date advances only on 11:59:59 with bit 22 set, going to 12:00:00 with bit 22 clear.
- R8: The date word holds day in bits 5:0, month in 12:8, weekday in 15:13 and year in 23:16, all in BCD. Months 04, 06, 09 and 11 have 30 days, and all months except 02 have 31. The day after the last one is 01 of the next month, and month 12 rolls to 01 and increments the year.
- R9: February ends on day 29 when the binary year value is divisible by 4 (00 included), and on day 28 otherwise.
- R10: Each day advance moves the weekday to the next value in the cycle 1 to 7; 7 is followed by 1.
- R11: Year 99 rolls to 00 at the end of December.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Stop prescaler and calendar; enables loads |
| div_async | input | 7 | First divider setting A (divide by A+1) |
| div_sync | input | 15 | Second divider setting S (divide by S+1) |
| hour12 | input | 1 | 1 selects 12-hour format with PM flag |
| load_time | input | 1 | Load strobe for the time word |
| time_wdata | input | 23 | New time word |
| load_date | input | 1 | Load strobe for the date word |
| date_wdata | input | 24 | New date word |
| time_q | output | 23 | Packed BCD time word |
| date_q | output | 24 | Packed BCD date word |
| sec_tick | output | 1 | One-cycle pulse on each calendar step |

## Verification
The in-line properties watch, on every cycle, that the prescaler is cleared under freeze and that the second divider moves only when the first wraps. They also check that both words hold between ticks and ignore loads while running, that seconds wrap after 59, that midnight clears the hours, and that the weekday and year wrap. The exact tick spacing, month lengths, the leap-year decision, the 12-hour PM sequence and the multi-field carries at month and year ends depend on particular loaded values. Only the bench's directed scenarios show those, by comparing the words with values worked out by hand.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int TIME_W = 23;
  localparam int DATE_W = 24;

  // Increment a two-digit BCD value (00..99 -> next, 99 -> 00).
  function automatic logic [7:0] bcd8_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) begin
      r[3:0] = 4'd0;
      r[7:4] = (v[7:4] == 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      r[3:0] = v[3:0] + 4'd1;
      r[7:4] = v[7:4];
    end
    return r;
  endfunction

  // Two-digit BCD to binary.
  function automatic logic [7:0] bcd8_to_bin(input logic [7:0] v);
    logic [7:0] tens;
    tens = {4'd0, v[7:4]};
    return (tens * 8'd10) + {4'd0, v[3:0]};
  endfunction

  // Leap rule valid across 2000..2099.
  function automatic logic year_is_leap(input logic [7:0] yr_bcd);
    logic [7:0] b;
    b = bcd8_to_bin(yr_bcd);
    return (b[1:0] == 2'b00);
  endfunction

  // Last day of a month, in BCD.
  function automatic logic [5:0] month_last_day(input logic [4:0] mon,
                                                input logic [7:0] yr_bcd);
    logic [5:0] d;
    case (mon)
      5'h02:                      d = year_is_leap(yr_bcd) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int A_W = 7,
  parameter int S_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           freeze,
  input  logic [A_W-1:0] div_a,
  input  logic [S_W-1:0] div_s,
  output logic           tick
);

  logic [A_W-1:0] a_q;
  logic [S_W-1:0] s_q;
  logic           a_wrap;
  logic           s_wrap;

  assign a_wrap = (a_q == div_a);
  assign s_wrap = (s_q == div_s);
  assign tick   = !freeze && a_wrap && s_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      s_q <= '0;
    end else if (freeze) begin
      a_q <= '0;
      s_q <= '0;
    end else if (a_wrap) begin
      a_q <= '0;
      s_q <= s_wrap ? '0 : s_q + 1'b1;
    end else begin
      a_q <= a_q + 1'b1;
    end
  end

  // R3: frozen prescaler restarts from zero
  a_r3_frozen_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (a_q == '0 && s_q == '0));

  // R2: second stage advances only when the first stage wraps
  a_r2_sync_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !a_wrap) |=> (s_q == $past(s_q)));

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              tick,
  input  logic              hour12,
  input  logic              ld,
  input  logic [TIME_W-1:0] ld_val,
  output logic [TIME_W-1:0] time_q,
  output logic              day_carry
);

  logic [6:0] sec, mins;
  logic [5:0] hr;
  logic       pm;
  logic       sec_wrap, min_wrap, hr_last;
  logic [6:0] sec_n, min_n;
  logic [5:0] hr_n;
  logic       pm_n;
  logic [7:0] sec_inc, min_inc, hr_inc;

  assign sec = time_q[6:0];
  assign mins = time_q[14:8];
  assign hr  = time_q[21:16];
  assign pm  = time_q[22];

  assign sec_wrap = (sec == 7'h59);
  assign min_wrap = (mins == 7'h59);
  assign hr_last  = hour12 ? (hr == 6'h11 && pm) : (hr == 6'h23);
  assign day_carry = tick && sec_wrap && min_wrap && hr_last;

  assign sec_inc = bcd8_inc({1'b0, sec});
  assign min_inc = bcd8_inc({1'b0, mins});
  assign hr_inc  = bcd8_inc({2'b00, hr});

  always_comb begin
    sec_n = sec_wrap ? 7'h00 : sec_inc[6:0];
    min_n = mins;
    hr_n  = hr;
    pm_n  = pm;
    if (sec_wrap) begin
      min_n = min_wrap ? 7'h00 : min_inc[6:0];
      if (min_wrap) begin
        if (hour12) begin
          if (hr == 6'h12) begin
            hr_n = 6'h01;
          end else if (hr == 6'h11) begin
            hr_n = 6'h12;
            pm_n = !pm;
          end else begin
            hr_n = hr_inc[5:0];
          end
        end else begin
          hr_n = (hr == 6'h23) ? 6'h00 : hr_inc[5:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (freeze) begin
      if (ld) time_q <= ld_val;
    end else if (tick) begin
      time_q <= {pm_n, hr_n, 1'b0, min_n, 1'b0, sec_n};
    end
  end

  // R4: running and no tick means the word holds, loads included
  a_r4_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !tick) |=> $stable(time_q));

  // R5: seconds wrap after 59
  a_r5_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec == 7'h59) |=> (time_q[6:0] == 7'h00));

  // R6: midnight in 24-hour format clears the hours
  a_r6_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !hour12) |=> (time_q[21:16] == 6'h00));

endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              day_inc,
  input  logic              ld,
  input  logic [DATE_W-1:0] ld_val,
  output logic [DATE_W-1:0] date_q
);

  logic [5:0] day;
  logic [4:0] mon;
  logic [2:0] wd;
  logic [7:0] yr;
  logic [5:0] last_day;
  logic       at_end, mon_end;
  logic [5:0] day_n;
  logic [4:0] mon_n;
  logic [2:0] wd_n;
  logic [7:0] yr_n;
  logic [7:0] day_inc8, mon_inc8;

  assign day = date_q[5:0];
  assign mon = date_q[12:8];
  assign wd  = date_q[15:13];
  assign yr  = date_q[23:16];

  assign last_day = month_last_day(mon, yr);
  assign at_end   = (day == last_day);
  assign mon_end  = (mon == 5'h12);
  assign day_inc8 = bcd8_inc({2'b00, day});
  assign mon_inc8 = bcd8_inc({3'b000, mon});

  always_comb begin
    day_n = day_inc8[5:0];
    mon_n = mon;
    yr_n  = yr;
    wd_n  = (wd == 3'd7) ? 3'd1 : wd + 3'd1;
    if (at_end) begin
      day_n = 6'h01;
      if (mon_end) begin
        mon_n = 5'h01;
        yr_n  = bcd8_inc(yr);
      end else begin
        mon_n = mon_inc8[4:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date_q <= '0;
    end else if (freeze) begin
      if (ld) date_q <= ld_val;
    end else if (day_inc) begin
      date_q <= {yr_n, wd_n, mon_n, 2'b00, day_n};
    end
  end

  // R4: date holds between day steps, loads included
  a_r4_date_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !day_inc) |=> $stable(date_q));

  // R10: weekday 7 is followed by 1
  a_r10_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && wd == 3'd7) |=> (date_q[15:13] == 3'd1));

  // R11: year 99 rolls to 00
  a_r11_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && at_end && mon_end && yr == 8'h99) |=> (date_q[23:16] == 8'h00));

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int A_W = 7,
  parameter int S_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic [A_W-1:0]    div_async,
  input  logic [S_W-1:0]    div_sync,
  input  logic              hour12,
  input  logic              load_time,
  input  logic [TIME_W-1:0] time_wdata,
  input  logic              load_date,
  input  logic [DATE_W-1:0] date_wdata,
  output logic [TIME_W-1:0] time_q,
  output logic [DATE_W-1:0] date_q,
  output logic              sec_tick
);

  logic day_carry;

  cal_prescaler #(.A_W(A_W), .S_W(S_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .freeze(freeze),
    .div_a (div_async),
    .div_s (div_sync),
    .tick  (sec_tick)
  );

  cal_time_chain u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (freeze),
    .tick     (sec_tick),
    .hour12   (hour12),
    .ld       (load_time),
    .ld_val   (time_wdata),
    .time_q   (time_q),
    .day_carry(day_carry)
  );

  cal_date_chain u_date (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (freeze),
    .day_inc(day_carry),
    .ld     (load_date),
    .ld_val (date_wdata),
    .date_q (date_q)
  );

  // R3: the calendar never steps while frozen
  a_r3_no_step_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !load_time && !load_date) |=> ($stable(time_q) && $stable(date_q)));

endmodule

// File: tb/bcd_calendar_core_tb_top.sv
module bcd_calendar_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b1;
  logic [6:0]  div_async = 7'd1;
  logic [14:0] div_sync = 15'd2;
  logic        hour12 = 1'b0;
  logic        load_time = 1'b0;
  logic [22:0] time_wdata = '0;
  logic        load_date = 1'b0;
  logic [23:0] date_wdata = '0;
  logic [22:0] time_q;
  logic [23:0] date_q;
  logic        sec_tick;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = !clk;

  bcd_calendar_core dut_i (
    .clk(clk), .rst_n(rst_n), .freeze(freeze),
    .div_async(div_async), .div_sync(div_sync), .hour12(hour12),
    .load_time(load_time), .time_wdata(time_wdata),
    .load_date(load_date), .date_wdata(date_wdata),
    .time_q(time_q), .date_q(date_q), .sec_tick(sec_tick)
  );

  function automatic logic [22:0] mk_t(input logic pm, input logic [7:0] h,
                                       input logic [7:0] m, input logic [7:0] s);
    return {pm, h[5:0], 1'b0, m[6:0], 1'b0, s[6:0]};
  endfunction

  function automatic logic [23:0] mk_d(input logic [7:0] y, input logic [2:0] w,
                                       input logic [7:0] mo, input logic [7:0] d);
    return {y, w, mo[4:0], 2'b00, d[5:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [22:0] t, input logic [23:0] d);
    @(negedge clk);
    freeze = 1'b1; load_time = 1'b1; load_date = 1'b1;
    time_wdata = t; date_wdata = d;
    @(negedge clk);
    load_time = 1'b0; load_date = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    int seen = 0;
    int guard = 0;
    @(negedge clk);
    freeze = 1'b0;
    while (seen < n && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (sec_tick) seen++;
    end
    @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    if (seen < n) chk("R2 tick missing", seen, n);
  endtask

  task automatic t_reset;
    chk("R1 time reset", time_q, 0);
    chk("R1 date reset", date_q, 0);
    chk("R1 tick reset", sec_tick, 0);
  endtask

  task automatic t_period;
    int c = 0;
    int c2 = 0;
    load('0, '0);
    @(negedge clk);
    freeze = 1'b0;
    do begin @(negedge clk); c++; end while (!sec_tick && c < 100);
    chk("R3 first tick after release", c, 5);
    do begin @(negedge clk); c2++; end while (!sec_tick && c2 < 100);
    chk("R2 tick interval", c2, 6);
    @(negedge clk);
    freeze = 1'b1;
    @(negedge clk);
    chk("R1 zero word counts", time_q, mk_t(0, 8'h00, 8'h00, 8'h02));
    c = 0;
    repeat (20) begin @(negedge clk); if (sec_tick) c++; end
    chk("R3 no tick frozen", c, 0);
    chk("R3 time held frozen", time_q, mk_t(0, 8'h00, 8'h00, 8'h02));
  endtask

  task automatic t_load_ignored;
    load(mk_t(0, 8'h10, 8'h20, 8'h30), mk_d(8'h24, 3'd2, 8'h05, 8'h14));
    @(negedge clk);
    freeze = 1'b0; load_time = 1'b1; load_date = 1'b1;
    time_wdata = mk_t(0, 8'h01, 8'h02, 8'h03);
    date_wdata = mk_d(8'h11, 3'd1, 8'h01, 8'h01);
    @(negedge clk);
    load_time = 1'b0; load_date = 1'b0; freeze = 1'b1;
    @(negedge clk);
    chk("R4 time load ignored", time_q, mk_t(0, 8'h10, 8'h20, 8'h30));
    chk("R4 date load ignored", date_q, mk_d(8'h24, 3'd2, 8'h05, 8'h14));
  endtask

  task automatic t_carry;
    hour12 = 1'b0;
    load(mk_t(0, 8'h12, 8'h59, 8'h59), mk_d(8'h24, 3'd2, 8'h05, 8'h14));
    run_ticks(1);
    chk("R5 min/hour carry", time_q, mk_t(0, 8'h13, 8'h00, 8'h00));
    load(mk_t(0, 8'h00, 8'h00, 8'h59), mk_d(8'h24, 3'd2, 8'h05, 8'h14));
    run_ticks(2);
    chk("R5 sec carry", time_q, mk_t(0, 8'h00, 8'h01, 8'h01));
    chk("R5 date untouched", date_q, mk_d(8'h24, 3'd2, 8'h05, 8'h14));
  endtask

  task automatic t_new_year;
    load(mk_t(0, 8'h23, 8'h59, 8'h58), mk_d(8'h23, 3'd7, 8'h12, 8'h31));
    run_ticks(2);
    chk("R6 midnight", time_q, mk_t(0, 8'h00, 8'h00, 8'h00));
    chk("R8 R10 new year", date_q, mk_d(8'h24, 3'd1, 8'h01, 8'h01));
  endtask

  task automatic t_month30;
    load(mk_t(0, 8'h23, 8'h59, 8'h59), mk_d(8'h24, 3'd3, 8'h04, 8'h30));
    run_ticks(1);
    chk("R8 30-day month", date_q, mk_d(8'h24, 3'd4, 8'h05, 8'h01));
    load(mk_t(0, 8'h23, 8'h59, 8'h59), mk_d(8'h24, 3'd3, 8'h08, 8'h30));
    run_ticks(1);
    chk("R8 31-day month", date_q, mk_d(8'h24, 3'd4, 8'h08, 8'h31));
  endtask

  task automatic t_feb;
    load(mk_t(0, 8'h23, 8'h59, 8'h59), mk_d(8'h24, 3'd5, 8'h02, 8'h28));
    run_ticks(1);
    chk("R9 leap 2024", date_q, mk_d(8'h24, 3'd6, 8'h02, 8'h29));
    load(mk_t(0, 8'h23, 8'h59, 8'h59), mk_d(8'h23, 3'd5, 8'h02, 8'h28));
    run_ticks(1);
    chk("R9 common 2023", date_q, mk_d(8'h23, 3'd6, 8'h03, 8'h01));
    load(mk_t(0, 8'h23, 8'h59, 8'h59), mk_d(8'h00, 3'd1, 8'h02, 8'h28));
    run_ticks(1);
    chk("R9 leap 2000", date_q, mk_d(8'h00, 3'd2, 8'h02, 8'h29));
    load(mk_t(0, 8'h23, 8'h59, 8'h59), mk_d(8'h96, 3'd4, 8'h02, 8'h29));
    run_ticks(1);
    chk("R9 leap end", date_q, mk_d(8'h96, 3'd5, 8'h03, 8'h01));
  endtask

  task automatic t_year99;
    load(mk_t(0, 8'h23, 8'h59, 8'h59), mk_d(8'h99, 3'd6, 8'h12, 8'h31));
    run_ticks(1);
    chk("R11 year wrap", date_q, mk_d(8'h00, 3'd7, 8'h01, 8'h01));
  endtask

  task automatic t_12h;
    hour12 = 1'b1;
    load(mk_t(0, 8'h11, 8'h59, 8'h59), mk_d(8'h24, 3'd2, 8'h05, 8'h14));
    run_ticks(1);
    chk("R7 noon", time_q, mk_t(1, 8'h12, 8'h00, 8'h00));
    chk("R7 no date step at noon", date_q, mk_d(8'h24, 3'd2, 8'h05, 8'h14));
    load(mk_t(1, 8'h12, 8'h59, 8'h59), mk_d(8'h24, 3'd2, 8'h05, 8'h14));
    run_ticks(1);
    chk("R7 12 to 01", time_q, mk_t(1, 8'h01, 8'h00, 8'h00));
    load(mk_t(1, 8'h11, 8'h59, 8'h59), mk_d(8'h24, 3'd2, 8'h05, 8'h14));
    run_ticks(1);
    chk("R7 midnight", time_q, mk_t(0, 8'h12, 8'h00, 8'h00));
    chk("R7 date step", date_q, mk_d(8'h24, 3'd3, 8'h05, 8'h15));
    hour12 = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_period();
    t_load_ignored();
    t_carry();
    t_new_year();
    t_month30();
    t_feb();
    t_year99();
    t_12h();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule